// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models a byte-wide parallel NOR flash array behind a command protocol that is entered through keyed write cycles. A host drives a synchronous bus with a 12-bit address, write data, a write strobe and a read strobe. Most writes are not stores. They advance a sequencer that recognises a two-cycle key pair followed by a command byte. Commands cover single-byte program, sector erase, whole-array erase, an identification view, a query view and a bypass mode in which commands need no key cycles. The array is 4 sectors of 256 bytes by default. The array index is the low 10 address bits, while command addresses are compared on all 12 bits.

Programming can only clear bits. A program takes one extra busy cycle, during which reads return a status byte. An erase sets bytes to 0xFF and then holds the block busy for a parameterised number of cycles. During that time every write is ignored and every read returns status.

States: `S_READ` (array view), `S_UNLK1` (first key seen), `S_UNLK2` (key pair done, waiting for the command), `S_PROG_DATA` (waiting for the program byte), `S_PROG_BUSY` (one status cycle), `S_ERS_U0` and `S_ERS_U1` (second key pair of an erase), `S_ERS_CMD` (waiting for the erase kind), `S_ERASE` (timed busy), `S_AUTOSEL` (identification view) and `S_CFI` (query view).

Transitions:
- `S_READ` goes to `S_UNLK1` on 0xAA@0x555 and to `S_CFI` on 0x98@0x055.
- In bypass, `S_READ` decodes the command directly.
- `S_UNLK1` goes to `S_UNLK2` on 0x55@0x2AA, and otherwise to `S_READ`.
- `S_UNLK2` decodes a command written to 0x555:
  - 0xA0 goes to `S_PROG_DATA`.
  - 0x80 goes to `S_ERS_U0`.
  - 0x90 goes to `S_AUTOSEL`.
  - 0x20 sets bypass and goes to `S_READ`.
  - Any other byte goes to `S_READ`.
- `S_PROG_DATA` goes to `S_PROG_BUSY`, and `S_PROG_BUSY` then goes to `S_READ`.
- `S_ERS_U0` goes to `S_ERS_U1`, then to `S_ERS_CMD`, then to `S_ERASE`. A malformed cycle at any of these steps goes to `S_READ`.
- `S_ERASE` goes to `S_READ` when the timer expires.
- `S_AUTOSEL` goes to `S_CFI` on 0x98@0x055, and otherwise to `S_READ`.
- `S_CFI` goes to `S_READ` on any write.
- 0xF0 goes to `S_READ` from every state except `S_PROG_DATA` and `S_ERASE`.

Top module: `nor_cmd_seq`

## Requirements
- R1: From S_READ without bypass, a write of 0xAA at address 0x555 followed by 0x55 at address 0x2AA completes the key pair. Any other second write returns the block to read mode with the array unchanged.
- R2: Without bypass, the command byte after a key pair is accepted only at address 0x555. A command at any other address returns the block to read mode, and the following data write changes nothing.
- R3: Writing 0x98 at address 0x055 in read mode or identification mode enters query mode. Query-mode reads return 0x00. Any write in query mode returns the block to read mode.
- R4: A write of 0xF0 returns the block to read mode from any state except erase-busy. While a program byte is pending, 0xF0 is taken as program data instead.
- R5: Program (command 0xA0) stores the bitwise AND of the old byte and the next written byte, at the array index addr[9:0].
- R6: For the one cycle after the program data write, a read returns the status byte ~(data & 0x80): 0x7F when data bit 7 is 1, and 0xFF when it is 0.
- R7: Command 0x80, a second key pair, then 0x30 at any address sets all 256 bytes of the sector addr[9:8] to 0xFF and leaves the other sectors unchanged. busy is then high for exactly SECTOR_ERASE_CYCLES cycles.
- R8: While busy is high, every write is ignored (0xF0 included) and every read returns 0x00. When busy falls, the block is in read mode.
- R9: The final erase byte 0x10 at address 0x555 sets the whole array to 0xFF, with busy high for CHIP_ERASE_CYCLES cycles. Any other final erase cycle returns the block to read mode with no erase and no busy.
- R10: Command 0x90 enters identification mode. Reads with addr[1:0]=0 return MFR_ID, reads with addr[1:0]=1 return DEV_ID, and all other reads return 0x00.
- R11: Command 0x20 enters bypass. In bypass, command bytes are decoded from read mode at any address with no key pair, and a write of 0x00 leaves bypass.
- R12: After reset the array reads all 0xFF, busy is low and the block is in read mode. Read data appears one cycle after rd_en. Reads taken between key cycles return array data. An unknown command byte returns the block to read mode with the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address; command decode on all bits, array index on addr[9:0] |
| wr_data | input | 8 | Write byte (command, key or program data) |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read result, valid the cycle after rd_en |
| busy | output | 1 | High while an erase is in progress |

## Verification
Several properties are checked on every cycle:
- A broken key pair always falls back to read mode.
- A write always leaves query mode.
- The erase state holds until its timer ends, and the timer stays within its bound.
- Reads taken while busy return 0x00.
- A programmed byte never gains a 1 bit.

Other behaviour only the bench's scenarios can show: the exact erase lengths, which bytes an erase covers, the identification values, bypass entry and exit, and the 0xF0 corner cases. The bench compares each of these against its own byte-array model, using random program traffic and directed sequences.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int CMD_AW = 12;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_READ, S_UNLK1, S_UNLK2, S_PROG_DATA, S_PROG_BUSY,
        S_ERS_U0, S_ERS_U1, S_ERS_CMD, S_ERASE, S_AUTOSEL, S_CFI
    } seq_state_e;

    localparam logic [BYTE_W-1:0] KEY_A        = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_B        = 8'h55;
    localparam logic [BYTE_W-1:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_ERASE    = 8'h80;
    localparam logic [BYTE_W-1:0] CMD_CHIP     = 8'h10;
    localparam logic [BYTE_W-1:0] CMD_SECTOR   = 8'h30;
    localparam logic [BYTE_W-1:0] CMD_AUTOSEL  = 8'h90;
    localparam logic [BYTE_W-1:0] CMD_BYPASS   = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_BYP_EXIT = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_RESET    = 8'hF0;
    localparam logic [BYTE_W-1:0] CMD_QUERY    = 8'h98;

    localparam logic [CMD_AW-1:0] ADR_KEY_A = 12'h555;
    localparam logic [CMD_AW-1:0] ADR_KEY_B = 12'h2AA;
    localparam logic [CMD_AW-1:0] ADR_QUERY = 12'h055;

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int MAX_CNT = 640,
    localparam int CW = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == CW'(1));

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_CNT)); // R7

endmodule

// File: rtl/nor_array.sv
module nor_array #(
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 256,
    localparam int WORDS = SECTORS * SECTOR_BYTES,
    localparam int AW    = $clog2(WORDS),
    localparam int OFF_W = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] wr_idx,
    input  logic          prog_en,
    input  logic [7:0]    prog_data,
    input  logic          erase_all,
    input  logic          erase_sec,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_word
);
    logic [7:0] mem [WORDS];

    function automatic logic [AW-OFF_W-1:0] sec_of(input logic [AW-1:0] a);
        return a[AW-1:OFF_W];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (erase_all || (erase_sec && sec_of(AW'(i)) == sec_of(wr_idx)))
                    mem[i] <= 8'hFF;
                else if (prog_en && AW'(i) == wr_idx)
                    mem[i] <= mem[i] & prog_data;
            end
        end
    end

    assign rd_word = mem[rd_idx];

    AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en && !erase_all && !erase_sec
        |=> (mem[$past(wr_idx)] & ~$past(mem[wr_idx])) == 8'h00); // R5

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int          SECTORS             = 4,
    parameter int          SECTOR_BYTES        = 256,
    parameter int          SECTOR_ERASE_CYCLES = 64,
    parameter int          CHIP_ERASE_CYCLES   = 640,
    parameter logic [7:0]  MFR_ID              = 8'h01,
    parameter logic [7:0]  DEV_ID              = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_AW-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int AW = $clog2(SECTORS * SECTOR_BYTES);
    localparam int TW = $clog2(CHIP_ERASE_CYCLES + 1);

    seq_state_e    st_q, st_d;
    logic          byp_q, byp_d;
    logic [7:0]    stat_q, stat_d;
    logic          prog_en, ers_all, ers_sec, tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic [7:0]    arr_word, rd_mux;

    nor_array #(.SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_idx(addr[AW-1:0]), .prog_en(prog_en),
        .prog_data(wr_data), .erase_all(ers_all), .erase_sec(ers_sec),
        .rd_idx(addr[AW-1:0]), .rd_word(arr_word)
    );

    nor_busy_timer #(.MAX_CNT(CHIP_ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    function automatic seq_state_e cmd_next(input logic [7:0] c);
        unique case (c)
            CMD_PROGRAM: return S_PROG_DATA;
            CMD_ERASE:   return S_ERS_U0;
            CMD_AUTOSEL: return S_AUTOSEL;
            default:     return S_READ;
        endcase
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_READ;
            byp_q  <= 1'b0;
            stat_q <= 8'h00;
        end else begin
            st_q   <= st_d;
            byp_q  <= byp_d;
            stat_q <= stat_d;
        end
    end

    // next state and array strobes
    always_comb begin
        st_d     = st_q;
        byp_d    = byp_q;
        stat_d   = stat_q;
        prog_en  = 1'b0;
        ers_all  = 1'b0;
        ers_sec  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (st_q == S_PROG_BUSY) st_d = S_READ;
        if (st_q == S_ERASE) begin
            if (tmr_done) st_d = S_READ;
        end else if (wr_en) begin
            if (wr_data == CMD_RESET && st_q != S_PROG_DATA) begin
                st_d = S_READ;
            end else begin
                unique case (st_q)
                    S_READ, S_PROG_BUSY: begin
                        if (byp_q) begin
                            st_d = cmd_next(wr_data);
                            if (wr_data == CMD_BYP_EXIT) byp_d = 1'b0;
                        end else if (addr == ADR_QUERY && wr_data == CMD_QUERY)
                            st_d = S_CFI;
                        else if (addr == ADR_KEY_A && wr_data == KEY_A)
                            st_d = S_UNLK1;
                    end
                    S_UNLK1:
                        st_d = (addr == ADR_KEY_B && wr_data == KEY_B) ? S_UNLK2 : S_READ;
                    S_UNLK2: begin
                        st_d = (addr == ADR_KEY_A) ? cmd_next(wr_data) : S_READ;
                        if (addr == ADR_KEY_A && wr_data == CMD_BYPASS) byp_d = 1'b1;
                    end
                    S_PROG_DATA: begin
                        prog_en = 1'b1;
                        stat_d  = ~(wr_data & 8'h80);
                        st_d    = S_PROG_BUSY;
                    end
                    S_ERS_U0:
                        st_d = (addr == ADR_KEY_A && wr_data == KEY_A) ? S_ERS_U1 : S_READ;
                    S_ERS_U1:
                        st_d = (addr == ADR_KEY_B && wr_data == KEY_B) ? S_ERS_CMD : S_READ;
                    S_ERS_CMD: begin
                        st_d   = S_READ;
                        stat_d = 8'h00;
                        if (wr_data == CMD_CHIP && addr == ADR_KEY_A) begin
                            ers_all  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(CHIP_ERASE_CYCLES);
                            st_d     = S_ERASE;
                        end else if (wr_data == CMD_SECTOR) begin
                            ers_sec  = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(SECTOR_ERASE_CYCLES);
                            st_d     = S_ERASE;
                        end
                    end
                    S_AUTOSEL:
                        st_d = (addr == ADR_QUERY && wr_data == CMD_QUERY) ? S_CFI : S_READ;
                    S_CFI:
                        st_d = S_READ;
                    default:
                        st_d = S_READ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            S_PROG_BUSY, S_ERASE: rd_mux = stat_q;
            S_AUTOSEL: rd_mux = (addr[1:0] == 2'd0) ? MFR_ID :
                                (addr[1:0] == 2'd1) ? DEV_ID : 8'h00;
            S_CFI:     rd_mux = 8'h00;
            default:   rd_mux = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign busy = (st_q == S_ERASE);

    AST_BAD_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_UNLK1 && wr_en && !(addr == ADR_KEY_B && wr_data == KEY_B)
        |=> st_q == S_READ); // R1
    AST_CFI_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_CFI && wr_en |=> st_q == S_READ); // R3
    AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_ERASE && !tmr_done |=> st_q == S_ERASE); // R8
    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && busy |=> rd_data == 8'h00); // R8

endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
    localparam int SEC_CYC  = 64;
    localparam int CHIP_CYC = 640;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        busy;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] ref_mem [1024];

    always #2 clk = ~clk;

    nor_cmd_seq dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .busy(busy));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] q);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic keys();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
    endtask

    function automatic logic [7:0] prog_status(input logic [7:0] d);
        return ~(d & 8'h80);
    endfunction

    task automatic check_all(input string tag);
        logic [7:0] q;
        for (int i = 0; i < 1024; i++) begin
            rd(12'(i), q);
            chk(tag, q, ref_mem[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        chk("R12 busy after reset", busy, 0);
        rd(12'h000, q); chk("R12 reset array", q, 8'hFF);
        rd(12'h3FF, q); chk("R12 reset array", q, 8'hFF);

        // R5 R6: directed program and status
        keys(); wr(12'h555, 8'hA0); wr(12'h010, 8'h3C);
        ref_mem[16] = 8'h3C;
        rd(12'h010, q); chk("R6 status d7=0", q, prog_status(8'h3C));
        rd(12'h010, q); chk("R5 program", q, 8'h3C);
        keys(); wr(12'h555, 8'hA0); wr(12'h010, 8'hA5);
        ref_mem[16] = ref_mem[16] & 8'hA5;
        rd(12'h010, q); chk("R6 status d7=1", q, prog_status(8'hA5));
        rd(12'h010, q); chk("R5 AND only clears", q, 8'h24);

        // R5: random programs, aliased upper address bits
        for (int k = 0; k < 40; k++) begin
            logic [11:0] a;
            logic [7:0]  d;
            a = 12'($urandom_range(0, 4095));
            d = 8'($urandom);
            keys(); wr(12'h555, 8'hA0); wr(a, d);
            ref_mem[a[9:0]] = ref_mem[a[9:0]] & d;
            rd(a, q); chk("R6 random status", q, prog_status(d));
            rd(12'($urandom_range(0, 4095)) & 12'hFFF, q);
        end
        for (int k = 0; k < 30; k++) begin
            logic [11:0] a;
            a = 12'($urandom_range(0, 4095));
            rd(a, q); chk("R5 random readback", q, ref_mem[a[9:0]]);
        end

        // R1: broken key pair, then stray writes do nothing
        wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55);
        wr(12'h555, 8'hA0); wr(12'h020, 8'h00);
        rd(12'h020, q); chk("R1 broken key pair", q, ref_mem[32]);

        // R2: command at wrong address
        keys(); wr(12'h554, 8'hA0); wr(12'h021, 8'h00);
        rd(12'h021, q); chk("R2 command address", q, ref_mem[33]);

        // R12: reads between key cycles, unknown command
        wr(12'h555, 8'hAA); rd(12'h010, q); chk("R12 read in key cycle", q, ref_mem[16]);
        wr(12'h2AA, 8'h55); rd(12'h011, q); chk("R12 read in key cycle", q, ref_mem[17]);
        wr(12'h555, 8'hA0); wr(12'h022, 8'h0F); ref_mem[34] &= 8'h0F;
        rd(12'h022, q); rd(12'h022, q); chk("R12 program after reads", q, ref_mem[34]);
        keys(); wr(12'h555, 8'h77); wr(12'h023, 8'h00);
        rd(12'h023, q); chk("R12 unknown command", q, ref_mem[35]);

        // R4: 0xF0 aborts, but is data when program pending
        keys(); wr(12'h000, 8'hF0); wr(12'h024, 8'h00);
        rd(12'h024, q); chk("R4 reset aborts", q, ref_mem[36]);
        keys(); wr(12'h555, 8'hA0); wr(12'h025, 8'hF0); ref_mem[37] &= 8'hF0;
        rd(12'h025, q); rd(12'h025, q); chk("R4 F0 as data", q, ref_mem[37]);

        // R10: identification view, then R3 query from it
        keys(); wr(12'h555, 8'h90);
        rd(12'h000, q); chk("R10 manufacturer", q, 8'h01);
        rd(12'h001, q); chk("R10 device", q, 8'h5A);
        rd(12'h002, q); chk("R10 unprotected", q, 8'h00);
        wr(12'h055, 8'h98);
        rd(12'h010, q); chk("R3 query from autoselect", q, 8'h00);
        wr(12'h000, 8'hF0);
        rd(12'h010, q); chk("R4 F0 leaves query", q, ref_mem[16]);

        // R3: query from read mode, exit on any write
        wr(12'h055, 8'h98);
        rd(12'h3FF, q); chk("R3 query read", q, 8'h00);
        wr(12'h026, 8'h00);
        rd(12'h026, q); chk("R3 write leaves query unchanged array", q, ref_mem[38]);

        // R11: bypass
        keys(); wr(12'h555, 8'h20);
        wr(12'h123, 8'hA0); wr(12'h0C8, 8'h81); ref_mem[200] &= 8'h81;
        rd(12'h0C8, q); chk("R11 bypass status", q, prog_status(8'h81));
        rd(12'h0C8, q); chk("R11 bypass program", q, ref_mem[200]);
        wr(12'h7FF, 8'hA0); wr(12'h0C9, 8'h12); ref_mem[201] &= 8'h12;
        rd(12'h0C9, q); rd(12'h0C9, q); chk("R11 bypass repeat", q, ref_mem[201]);
        wr(12'h000, 8'h00);
        wr(12'h123, 8'hA0); wr(12'h0CA, 8'h00);
        rd(12'h0CA, q); chk("R11 bypass exit", q, ref_mem[202]);

        // R7 R8: sector erase
        keys(); wr(12'h555, 8'h80); keys(); wr(12'h2A7, 8'h30);
        for (int i = 512; i < 768; i++) ref_mem[i] = 8'hFF;
        chk("R8 busy raised", busy, 1);
        rd(12'h2A7, q); chk("R8 status during erase", q, 8'h00);
        wr(12'h000, 8'hF0);
        n = 2;
        while (busy && n < 100000) begin n++; @(negedge clk); end
        chk("R7 sector busy length", n, SEC_CYC);
        rd(12'h2A7, q); chk("R8 read mode after erase", q, 8'hFF);
        check_all("R7 sector contents");

        // R9: malformed chip erase, then real chip erase
        keys(); wr(12'h555, 8'h80); keys(); wr(12'h123, 8'h10);
        chk("R9 malformed no busy", busy, 0);
        rd(12'h010, q); chk("R9 malformed no erase", q, ref_mem[16]);
        keys(); wr(12'h555, 8'h80); keys(); wr(12'h555, 8'h10);
        for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
        n = 0;
        while (busy && n < 100000) begin n++; @(negedge clk); end
        chk("R9 chip busy length", n, CHIP_CYC);
        check_all("R9 chip contents");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule